// File: doc/BRIEF.md
# DMA Channel Register File

This block holds the software-visible registers of a multi-channel, descriptor-driven DMA controller. Each channel owns a 128-byte window in a 4 KB bus region. The window holds a raw control word, a status word, a command pointer split into two words, three condition-select words (interrupt, branch, wait) and a transfer-mode word. A 32-bit memory-mapped bus writes these registers, and reads of them are combinational. The command engine that walks descriptors sits outside this block. It sees one selected channel's status, command pointer and select words, and it can replace that channel's status word.

Software never writes status directly. A control write carries a per-bit mask in its upper half-word and new bit values in its lower half-word. Only the run, pause, flush and wake flags and the device-status byte can take a new value this way. Stopping a running channel also clears its active and dead flags. The low command-pointer word is locked while the channel is running or active. When a write to it is accepted, the address is forced to 16-byte alignment and a fetch request goes to the engine. A control write that leaves a channel both running and active sends the engine a run request.

Top module: `dma_chan_regfile`

## Requirements
- R1: After reset every register of every channel reads zero, and fetch_o and run_req_o are low.
- R2: A bus address decodes as channel = addr[11:7] and word offset = addr[6:2]. Offsets 0 (control), 2 (pointer high), 3 (pointer low), 4 (interrupt select), 5 (branch select), 6 (wait select) and 7 (transfer mode) read back the stored word. Offset 1 reads status.
- R3: A write to offset 0 stores the written word as control. It also sets status[15:0] to (v & m) | (s & ~m), where m = wdata[31:15:16 half] i.e. wdata[31:16], v is the filtered value of R4, and s is the status before the write. Status bits 31:16 keep their value.
- R4: Status bit positions are RUN 15, PAUSE 14, FLUSH 13, WAKE 12, DEAD 11, ACTIVE 10 and BRANCHED 8, with the device status in bits 7:0. Before the merge of R3, v keeps wdata bits 15:12 and 7:0 and forces bits 11:8 to zero.
- R5: When a control write takes RUN from 1 to 0, ACTIVE and DEAD are cleared in the same update.
- R6: A write to offset 3 is ignored while the channel's status has RUN or ACTIVE set. The pointer keeps its value and no fetch request is issued.
- R7: An accepted write to offset 3 stores wdata with bits 3:0 cleared. In the next cycle fetch_o is high for one cycle, fetch_ch_o gives the channel and fetch_addr_o gives the aligned address.
- R8: In the cycle after a control write whose resulting status has both RUN and ACTIVE set, run_req_o is high for one cycle and run_ch_o gives the channel. Writes that are not control writes never raise run_req_o.
- R9: Offsets 8 to 31 read zero and ignore writes. Writes to the status offset are ignored. Channels at or above NUM_CH read zero and ignore writes.
- R10: When eng_upd_i is high, the status of channel eng_ch_i is replaced by eng_status_i. A control write to the same channel in the same cycle merges on top of the engine's value. The eng_*_o outputs show the channel selected by eng_ch_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | ADDR_W | Byte address inside the region |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| eng_ch_i | input | CH_W | Channel selected by the engine |
| eng_upd_i | input | 1 | Engine status replace strobe |
| eng_status_i | input | 32 | Status word from the engine |
| eng_status_o | output | 32 | Status of the selected channel |
| eng_ptr_o | output | 32 | Low command pointer of the selected channel |
| eng_isel_o | output | 32 | Interrupt select of the selected channel |
| eng_bsel_o | output | 32 | Branch select of the selected channel |
| eng_wsel_o | output | 32 | Wait select of the selected channel |
| fetch_o | output | 1 | Descriptor fetch request pulse |
| fetch_ch_o | output | CH_W | Channel of the fetch request |
| fetch_addr_o | output | 32 | Aligned descriptor address |
| run_req_o | output | 1 | Run request pulse |
| run_ch_o | output | CH_W | Channel of the run request |

## Verification
The assertions assume that the channel field of an address below NUM_CH names a channel that really exists. They also assume that the engine does not rewrite the status of the channel named by run_ch_o in the cycle that run_req_o is checked. The bench drives engine updates only as separate steps, or in one directed case on a channel that has no pending pulse. It waits for the pulse cycle to pass before the next engine update, so the status seen next to a pulse is always the value the triggering write produced.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int OFF_CTRL   = 0;
  localparam int OFF_STAT   = 1;
  localparam int OFF_PTR_HI = 2;
  localparam int OFF_PTR_LO = 3;
  localparam int OFF_ISEL   = 4;
  localparam int OFF_BSEL   = 5;
  localparam int OFF_WSEL   = 6;
  localparam int OFF_XMODE  = 7;

  localparam int ST_RUN    = 15;
  localparam int ST_PAUSE  = 14;
  localparam int ST_FLUSH  = 13;
  localparam int ST_WAKE   = 12;
  localparam int ST_DEAD   = 11;
  localparam int ST_ACTIVE = 10;
  localparam int ST_BRANCH = 8;

  // value bits a control write may carry into status
  localparam logic [15:0] CTRL_VAL_KEEP = 16'hF0FF;
  localparam logic [31:0] PTR_ALIGN     = 32'hFFFF_FFF0;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] status;
    logic [31:0] ptr_hi;
    logic [31:0] ptr_lo;
    logic [31:0] isel;
    logic [31:0] bsel;
    logic [31:0] wsel;
    logic [31:0] xmode;
  } chan_regs_t;
endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode #(
  parameter int ADDR_W   = 12,
  parameter int CH_SHIFT = 7,
  parameter int NUM_CH   = 32,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int FLD_W   = ADDR_W - CH_SHIFT,
  localparam int OFF_W   = CH_SHIFT - 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CH_W-1:0]   ch_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              ch_ok_o
);
  logic [FLD_W-1:0] fld;

  assign fld     = addr_i[ADDR_W-1:CH_SHIFT];
  assign off_o   = addr_i[CH_SHIFT-1:2];
  assign ch_ok_o = ({{(32-FLD_W){1'b0}}, fld} < 32'(NUM_CH));
  assign ch_o    = CH_W'(fld);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int OFF_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] wr_off_i,
  input  logic [31:0]      wdata_i,
  input  logic             upd_i,
  input  logic [31:0]      upd_status_i,
  output chan_regs_t       regs_o,
  output logic             fetch_req_o,
  output logic             run_req_o
);
  chan_regs_t  q;
  logic [31:0] st_base, st_next;
  logic [15:0] mask, val, merged;
  logic        ctrl_wr, ptr_wr, locked;

  assign ctrl_wr = wr_i && (wr_off_i == OFF_W'(OFF_CTRL));
  assign ptr_wr  = wr_i && (wr_off_i == OFF_W'(OFF_PTR_LO));
  assign locked  = q.status[ST_RUN] | q.status[ST_ACTIVE];
  assign fetch_req_o = ptr_wr && !locked;

  always_comb begin
    st_base = upd_i ? upd_status_i : q.status;
    mask    = wdata_i[31:16];
    val     = wdata_i[15:0] & CTRL_VAL_KEEP;
    merged  = (val & mask) | (st_base[15:0] & ~mask);
    if (st_base[ST_RUN] && !merged[ST_RUN]) begin
      merged[ST_ACTIVE] = 1'b0;
      merged[ST_DEAD]   = 1'b0;
    end
    st_next   = ctrl_wr ? {st_base[31:16], merged} : st_base;
    run_req_o = ctrl_wr && merged[ST_RUN] && merged[ST_ACTIVE];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      q.status <= st_next;
      if (wr_i) begin
        unique case (int'(wr_off_i))
          OFF_CTRL:   q.ctrl   <= wdata_i;
          OFF_PTR_HI: q.ptr_hi <= wdata_i;
          OFF_PTR_LO: if (!locked) q.ptr_lo <= wdata_i & PTR_ALIGN;
          OFF_ISEL:   q.isel   <= wdata_i;
          OFF_BSEL:   q.bsel   <= wdata_i;
          OFF_WSEL:   q.wsel   <= wdata_i;
          OFF_XMODE:  q.xmode  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign regs_o = q;
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int ADDR_W   = 12,
  parameter int CH_SHIFT = 7,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int OFF_W   = CH_SHIFT - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [CH_W-1:0]   eng_ch_i,
  input  logic              eng_upd_i,
  input  logic [31:0]       eng_status_i,
  output logic [31:0]       eng_status_o,
  output logic [31:0]       eng_ptr_o,
  output logic [31:0]       eng_isel_o,
  output logic [31:0]       eng_bsel_o,
  output logic [31:0]       eng_wsel_o,
  output logic              fetch_o,
  output logic [CH_W-1:0]   fetch_ch_o,
  output logic [31:0]       fetch_addr_o,
  output logic              run_req_o,
  output logic [CH_W-1:0]   run_ch_o
);
  logic [CH_W-1:0]  bus_ch;
  logic [OFF_W-1:0] bus_off;
  logic             bus_ch_ok, eng_ok;

  chan_regs_t        regs_a   [NUM_CH];
  logic [31:0]       status_a [NUM_CH];
  logic [NUM_CH-1:0] fetch_req, run_req;

  dma_reg_decode #(
    .ADDR_W(ADDR_W), .CH_SHIFT(CH_SHIFT), .NUM_CH(NUM_CH)
  ) u_dec (
    .addr_i(bus_addr_i), .ch_o(bus_ch), .off_o(bus_off), .ch_ok_o(bus_ch_ok)
  );

  assign eng_ok = ({{(32-CH_W){1'b0}}, eng_ch_i} < 32'(NUM_CH));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_hit, upd_hit;
    assign wr_hit  = bus_we_i && bus_ch_ok && (bus_ch == CH_W'(c));
    assign upd_hit = eng_upd_i && eng_ok && (eng_ch_i == CH_W'(c));

    dma_chan_regs #(.OFF_W(OFF_W)) u_regs (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_i         (wr_hit),
      .wr_off_i     (bus_off),
      .wdata_i      (bus_wdata_i),
      .upd_i        (upd_hit),
      .upd_status_i (eng_status_i),
      .regs_o       (regs_a[c]),
      .fetch_req_o  (fetch_req[c]),
      .run_req_o    (run_req[c])
    );
    assign status_a[c] = regs_a[c].status;
  end

  always_comb begin
    chan_regs_t r;
    r = '0;
    if (bus_ch_ok) r = regs_a[bus_ch];
    unique case (int'(bus_off))
      OFF_CTRL:   bus_rdata_o = r.ctrl;
      OFF_STAT:   bus_rdata_o = r.status;
      OFF_PTR_HI: bus_rdata_o = r.ptr_hi;
      OFF_PTR_LO: bus_rdata_o = r.ptr_lo;
      OFF_ISEL:   bus_rdata_o = r.isel;
      OFF_BSEL:   bus_rdata_o = r.bsel;
      OFF_WSEL:   bus_rdata_o = r.wsel;
      OFF_XMODE:  bus_rdata_o = r.xmode;
      default:    bus_rdata_o = '0;
    endcase
  end

  always_comb begin
    chan_regs_t e;
    e = '0;
    if (eng_ok) e = regs_a[eng_ch_i];
    eng_status_o = e.status;
    eng_ptr_o    = e.ptr_lo;
    eng_isel_o   = e.isel;
    eng_bsel_o   = e.bsel;
    eng_wsel_o   = e.wsel;
  end

  // one bus write per cycle: at most one request bit is set
  logic [CH_W-1:0] req_ch;
  always_comb begin
    req_ch = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (fetch_req[i] || run_req[i]) req_ch = CH_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_o      <= 1'b0;
      fetch_ch_o   <= '0;
      fetch_addr_o <= '0;
      run_req_o    <= 1'b0;
      run_ch_o     <= '0;
    end else begin
      fetch_o   <= |fetch_req;
      run_req_o <= |run_req;
      if (|fetch_req) begin
        fetch_ch_o   <= req_ch;
        fetch_addr_o <= bus_wdata_i & PTR_ALIGN;
      end
      if (|run_req) run_ch_o <= req_ch;
    end
  end
endmodule

// File: rtl/dma_chan_regfile_chk.sv
module dma_chan_regfile_chk #(
  parameter int NUM_CH   = 32,
  parameter int ADDR_W   = 12,
  parameter int CH_SHIFT = 7,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int FLD_W   = ADDR_W - CH_SHIFT
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic              fetch_o,
  input logic [CH_W-1:0]   fetch_ch_o,
  input logic [31:0]       fetch_addr_o,
  input logic              run_req_o,
  input logic [CH_W-1:0]   run_ch_o,
  input logic [31:0]       status_a [NUM_CH]
);
  logic [FLD_W-1:0] fld;
  logic [CH_W-1:0]  ch;
  logic             ch_ok, locked, ptr_wr, ctrl_wr;

  assign fld     = bus_addr_i[ADDR_W-1:CH_SHIFT];
  assign ch      = CH_W'(fld);
  assign ch_ok   = ({{(32-FLD_W){1'b0}}, fld} < 32'(NUM_CH));
  assign locked  = ch_ok && (status_a[ch][15] || status_a[ch][10]);
  assign ptr_wr  = bus_we_i && ch_ok && (bus_addr_i[CH_SHIFT-1:2] == 3);
  assign ctrl_wr = bus_we_i && ch_ok && (bus_addr_i[CH_SHIFT-1:2] == 0);

  p_ptr_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_wr && locked) |=> !fetch_o);

  p_fetch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_wr && !locked) |=> (fetch_o && fetch_ch_o == $past(ch) &&
                             fetch_addr_o == {$past(bus_wdata_i[31:4]), 4'b0}));

  p_run_state_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_req_o |-> (status_a[run_ch_o][15] && status_a[run_ch_o][10]));

  p_run_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> !run_req_o);
endmodule

bind dma_chan_regfile dma_chan_regfile_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_SHIFT(CH_SHIFT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .fetch_o(fetch_o), .fetch_ch_o(fetch_ch_o),
  .fetch_addr_o(fetch_addr_o), .run_req_o(run_req_o), .run_ch_o(run_ch_o),
  .status_a(status_a)
);

// File: tb/dma_chan_regfile_bench.sv
`timescale 1ns/1ps
module dma_chan_regfile_bench;
  localparam int NCH = 4;
  localparam int CW  = 2;

  logic        clk = 0, rst_ni = 0;
  logic        bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [CW-1:0] eng_ch = '0;
  logic        eng_upd = 0;
  logic [31:0] eng_status = '0;
  logic [31:0] e_st, e_ptr, e_is, e_bs, e_ws;
  logic        fetch, run_req;
  logic [CW-1:0] fetch_ch, run_ch;
  logic [31:0] fetch_addr;

  int checks = 0, errors = 0;
  logic        f_seen, r_seen;
  logic [CW-1:0] f_ch, r_ch;
  logic [31:0] f_addr;
  logic [31:0] m_st [NCH];
  logic [31:0] m_reg [NCH][8];

  always #10 clk = ~clk;

  dma_chan_regfile #(.NUM_CH(NCH)) u_dma_chan_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .eng_ch_i(eng_ch),
    .eng_upd_i(eng_upd), .eng_status_i(eng_status), .eng_status_o(e_st),
    .eng_ptr_o(e_ptr), .eng_isel_o(e_is), .eng_bsel_o(e_bs), .eng_wsel_o(e_ws),
    .fetch_o(fetch), .fetch_ch_o(fetch_ch), .fetch_addr_o(fetch_addr),
    .run_req_o(run_req), .run_ch_o(run_ch)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] adr(int ch, int off);
    return {5'(ch), 5'(off), 2'b00};
  endfunction

  function automatic logic [31:0] ctrl_apply(logic [31:0] s, logic [31:0] w);
    logic [15:0] m, v, n;
    m = w[31:16];
    v = w[15:0] & 16'hF0FF;
    n = (v & m) | (s[15:0] & ~m);
    if (s[15] && !n[15]) n = n & 16'hF3FF;
    return {s[31:16], n};
  endfunction

  task automatic capture();
    @(posedge clk); #1;
    bus_we = 0; eng_upd = 0;
    @(posedge clk); #1;
    f_seen = fetch; f_ch = fetch_ch; f_addr = fetch_addr;
    r_seen = run_req; r_ch = run_ch;
  endtask

  task automatic bus_wr(int ch, int off, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = adr(ch, off); bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
    f_seen = fetch; f_ch = fetch_ch; f_addr = fetch_addr;
    r_seen = run_req; r_ch = run_ch;
  endtask

  task automatic eng_set(int ch, logic [31:0] s);
    @(negedge clk);
    eng_upd = 1; eng_ch = CW'(ch); eng_status = s;
    @(posedge clk); #1;
    eng_upd = 0;
  endtask

  task automatic bus_rd(int ch, int off, output logic [31:0] d);
    @(negedge clk);
    bus_we = 0; bus_addr = adr(ch, off);
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0] d, w, s;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;

    // R1 reset state
    for (int c = 0; c < NCH; c++)
      for (int o = 0; o < 8; o++) begin
        bus_rd(c, o, d); check("R1", d, 0);
        m_reg[c][o] = 0;
      end
    for (int c = 0; c < NCH; c++) m_st[c] = 0;
    check("R1 fetch", {31'b0, fetch}, 0);
    check("R1 run", {31'b0, run_req}, 0);

    // R2 / R7 write and read back of plain words and the pointer
    for (int c = 0; c < NCH; c++)
      for (int o = 2; o < 8; o++) begin
        w = {8'(c * 37 + o), 8'(o * 19), 8'hC3 ^ 8'(c), 8'(o * 16 + c + 9)};
        bus_wr(c, o, w);
        if (o == 3) begin
          w = w & 32'hFFFF_FFF0;
          check("R7 fetch", {31'b0, f_seen}, 1);
          check("R7 ch", 32'(f_ch), 32'(c));
          check("R7 addr", f_addr, w);
        end
        m_reg[c][o] = w;
      end
    for (int c = 0; c < NCH; c++)
      for (int o = 2; o < 8; o++) begin
        bus_rd(c, o, d); check("R2", d, m_reg[c][o]);
      end
    @(posedge clk); #1 check("R7 pulse one cycle", {31'b0, fetch}, 0);

    // R9 reserved offsets, status offset, absent channels
    for (int c = 0; c < NCH; c++) begin
      for (int o = 8; o < 32; o += 5) begin
        bus_wr(c, o, 32'hDEAD_BEEF);
        bus_rd(c, o, d); check("R9 reserved", d, 0);
      end
      bus_wr(c, 1, 32'hFFFF_FFFF);
      bus_rd(c, 1, d); check("R9 status ro", d, m_st[c]);
    end
    bus_wr(7, 4, 32'h1234_5678);
    bus_rd(3, 4, d); check("R9 alias", d, m_reg[3][4]);
    bus_rd(7, 4, d); check("R9 absent", d, 0);
    bus_rd(5, 2, d); check("R9 absent", d, 0);

    // R3 R4 R5 R8 sweep of control mask/value against engine seeds
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 24; i++) begin
        s = {16'(i * 16'h111), 16'(i * 16'h3C5A) ^ 16'(c * 16'h1F07)};
        eng_set(c, s);
        w = {16'(i * 16'h2B3D) ^ 16'(c * 16'h8421), ~16'(i * 16'h1F2F)};
        bus_wr(c, 0, w);
        m_st[c] = ctrl_apply(s, w);
        m_reg[c][0] = w;
        check("R8 run", {31'b0, r_seen}, {31'b0, m_st[c][15] & m_st[c][10]});
        if (r_seen) check("R8 ch", 32'(r_ch), 32'(c));
        bus_rd(c, 1, d); check("R3", d, m_st[c]);
        bus_rd(c, 0, d); check("R2 ctrl", d, w);
      end

    // R4 filter of bits 11:8, upper half kept
    eng_set(0, 32'hABCD_0F00);
    bus_wr(0, 0, 32'hFFFF_FFFF);
    bus_rd(0, 1, d); check("R4", d, 32'hABCD_F0FF);
    // R5 stopping clears ACTIVE and DEAD
    eng_set(1, 32'h0000_8C05);
    bus_wr(1, 0, 32'h8000_0000);
    bus_rd(1, 1, d); check("R5", d, 32'h0000_0005);
    // R8 RUN kept with ACTIVE set gives run request
    eng_set(1, 32'h0000_8C05);
    bus_wr(1, 0, 32'h1000_1000);
    check("R8 run", {31'b0, r_seen}, 1);
    check("R8 ch", 32'(r_ch), 1);
    @(posedge clk); #1 check("R8 pulse one cycle", {31'b0, run_req}, 0);
    bus_wr(1, 4, 32'h0);
    check("R8 non-ctrl", {31'b0, r_seen}, 0);
    m_reg[1][4] = 0;

    // R6 pointer lock
    eng_set(2, 32'h0000_8000);
    bus_wr(2, 3, 32'h0000_0555);
    check("R6 no fetch", {31'b0, f_seen}, 0);
    bus_rd(2, 3, d); check("R6", d, m_reg[2][3]);
    eng_set(2, 32'h0000_0400);
    bus_wr(2, 3, 32'h0000_0777);
    check("R6 no fetch", {31'b0, f_seen}, 0);
    bus_rd(2, 3, d); check("R6", d, m_reg[2][3]);
    eng_set(2, 32'h0000_0000);
    bus_wr(2, 3, 32'h89AB_CDEF);
    check("R7 fetch", {31'b0, f_seen}, 1);
    check("R7 addr", f_addr, 32'h89AB_CDE0);
    m_reg[2][3] = 32'h89AB_CDE0;

    // R10 same-cycle engine update and control write
    @(negedge clk);
    eng_upd = 1; eng_ch = 2'd3; eng_status = 32'h0000_0C00;
    bus_we = 1; bus_addr = adr(3, 0); bus_wdata = 32'h8000_8000;
    @(posedge clk); #1;
    eng_upd = 0; bus_we = 0;
    check("R10 run", {31'b0, run_req}, 1);
    bus_rd(3, 1, d); check("R10", d, 32'h0000_8C00);
    eng_set(0, 32'h5A5A_0042);
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk); eng_ch = CW'(c); #1;
      if (c == 0) check("R10 view st", e_st, 32'h5A5A_0042);
      check("R10 view ptr", e_ptr, m_reg[c][3]);
      check("R10 view isel", e_is, m_reg[c][4]);
      check("R10 view bsel", e_bs, m_reg[c][5]);
      check("R10 view wsel", e_ws, m_reg[c][6]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule